// File: doc/BRIEF.md
# Scan-Synchronized Pixel Clock Generator

This block sits between a scanning microscope and a bank of photon timing channels. The microscope provides two level signals. One is high while a line is being scanned. The other is high while a frame is being scanned. From these the block builds a pixel clock that splits each scanned line into a fixed number of equal time slots. It also builds an enable that lets the timing channels record photons only while the mirror sweeps a line, and never during the carriage return.

Both microscope signals are asynchronous to the block clock, so each passes through a two-flop synchronizer first. A line starts on a rising edge of the synchronized line level, but only while the frame level is high. At that point the block latches the pixel period and the start offset from its configuration inputs. It raises the enable, waits the offset, and then emits exactly the configured number of pixel-clock periods. The offset lets a scanner that is mechanically misaligned be corrected by moving the first pixel edge relative to the enable. A pixel index and a line index are brought out. A frame-done pulse marks the end of the last line of a frame. A line that ends too early stops pixel generation and sets a sticky error flag.

Top module: `scan_pixclk_gen`

## Requirements
- R1: With `frame_in` high, `en_scan` rises on the third clock edge after the edge that first samples `line_in` high.
- R2: The first rising edge of `pix_clk` in a line comes `cfg_delay + 1` clock cycles after `en_scan` rises.
- R3: An accepted line that stays active long enough produces exactly NUM_PIX rising edges on `pix_clk`. Successive edges are P cycles apart, and each period is high for floor(P/2) cycles, where P is the effective period.
- R4: The effective period P is `cfg_period` when that value is 2 or more, and 2 when `cfg_period` is 0 or 1.
- R5: `pix_idx` is 0 for the first pixel of a line and goes up by one at each later pixel-clock rising edge, up to NUM_PIX-1.
- R6: `en_scan` falls on the third clock edge after the edge that first samples `line_in` low, and `pix_clk` is never high while `en_scan` is low.
- R7: A rising edge of `line_in` that arrives while `frame_in` is low is ignored: `en_scan` and `pix_clk` stay low, and `line_idx` and `short_err` do not change.
- R8: `line_idx` counts the lines that complete in the current frame. When line NUM_LINES completes, `frame_done` is high for one cycle and `line_idx` returns to 0. `line_idx` is also cleared while `frame_in` is low and no line is running.
- R9: If `line_in` falls before all NUM_PIX pixels have been produced, pixel generation stops, that line is not counted in `line_idx`, and `short_err` is set and stays set until reset.
- R10: While reset is applied, every output is 0.
- R11: `cfg_period` and `cfg_delay` are taken at the start of a line. Changing them during that line does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Line-scanning level from the microscope (asynchronous) |
| frame_in | input | 1 | Frame-scanning level from the microscope (asynchronous) |
| cfg_period | input | PER_W | Pixel period in clock cycles |
| cfg_delay | input | DLY_W | Cycles between the enable rising and the first pixel edge, minus one |
| pix_clk | output | 1 | Pixel clock |
| en_scan | output | 1 | Acquisition enable, a delayed copy of the line level |
| pix_idx | output | PIX_W | Index of the current pixel in the line |
| line_idx | output | LINE_W | Number of completed lines in the current frame |
| frame_done | output | 1 | One-cycle pulse after the last line of a frame |
| short_err | output | 1 | Sticky flag: a line ended before all its pixels |

## Verification
Every result is timed in clock edges from the edge that first samples a change on `line_in`. The enable rises or falls on edge 3. The first pixel edge comes on edge 4 + `cfg_delay`. Pixel k starts on edge 4 + `cfg_delay` + k·P. `line_idx` and `frame_done` update on edge 4 + `cfg_delay` + NUM_PIX·P.

The bench drives its inputs on falling clock edges and samples on falling edges. For each line it counts elapsed edges and compares the edge at which each event was seen against these formulas. Per line it records the enable edges, every pixel-clock edge and its spacing, the high time, and the index value, so every check lands on the edge the requirement names.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RUN   = 2'd2
  } eng_state_t;
endpackage

// File: rtl/scan_sync.sv
module scan_sync #(
  parameter int NSIG = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] async_in,
  output logic [NSIG-1:0] lvl
);
  for (genvar i = 0; i < NSIG; i++) begin : g_sync
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
      end
    end
    assign lvl[i] = sync_q;
  end
endmodule

// File: rtl/pix_engine.sv
module pix_engine
  import scan_pkg::*;
#(
  parameter int NUM_PIX = 256,
  parameter int PER_W   = 16,
  parameter int DLY_W   = 16,
  localparam int PIX_W  = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_lvl,
  input  logic             frame_lvl,
  input  logic [PER_W-1:0] cfg_period,
  input  logic [DLY_W-1:0] cfg_delay,
  output logic             pix_clk,
  output logic             en_scan,
  output logic [PIX_W-1:0] pix_idx,
  output logic             line_end,
  output logic             line_abort,
  output logic             eng_idle
);
  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(NUM_PIX - 1);
  localparam logic [PER_W-1:0] MIN_PER  = PER_W'(2);

  eng_state_t       state_q, state_d;
  logic [PER_W-1:0] per_q, per_d, half_q, half_d, phase_q, phase_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic [PIX_W-1:0] pix_q, pix_d;
  logic             en_q, en_d;
  logic             line_prev_q;
  logic             rise, start, last_phase;
  logic [PER_W-1:0] per_cl;

  assign rise       = line_lvl & ~line_prev_q;
  assign start      = rise & frame_lvl & (state_q == ST_IDLE);
  assign per_cl     = (cfg_period < MIN_PER) ? MIN_PER : cfg_period;
  assign last_phase = (phase_q == per_q - PER_W'(1));
  assign line_abort = (state_q != ST_IDLE) & ~line_lvl;
  assign line_end   = (state_q == ST_RUN) & line_lvl & last_phase & (pix_q == LAST_PIX);

  always_comb begin
    state_d = state_q;
    per_d   = per_q;
    half_d  = half_q;
    phase_d = phase_q;
    dcnt_d  = dcnt_q;
    pix_d   = pix_q;
    en_d    = en_q;
    if (!line_lvl) en_d = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_DELAY;
          per_d   = per_cl;
          half_d  = per_cl >> 1;
          dcnt_d  = cfg_delay;
          en_d    = 1'b1;
        end
      end
      ST_DELAY: begin
        if (line_abort) begin
          state_d = ST_IDLE;
        end else if (dcnt_q == '0) begin
          state_d = ST_RUN;
          phase_d = '0;
          pix_d   = '0;
        end else begin
          dcnt_d = dcnt_q - DLY_W'(1);
        end
      end
      ST_RUN: begin
        if (line_abort) begin
          state_d = ST_IDLE;
          phase_d = '0;
          pix_d   = '0;
        end else if (last_phase) begin
          phase_d = '0;
          if (pix_q == LAST_PIX) begin
            state_d = ST_IDLE;
            pix_d   = '0;
          end else begin
            pix_d = pix_q + PIX_W'(1);
          end
        end else begin
          phase_d = phase_q + PER_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      per_q       <= MIN_PER;
      half_q      <= PER_W'(1);
      phase_q     <= '0;
      dcnt_q      <= '0;
      pix_q       <= '0;
      en_q        <= 1'b0;
      line_prev_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      per_q       <= per_d;
      half_q      <= half_d;
      phase_q     <= phase_d;
      dcnt_q      <= dcnt_d;
      pix_q       <= pix_d;
      en_q        <= en_d;
      line_prev_q <= line_lvl;
    end
  end

  assign pix_clk  = (state_q == ST_RUN) & (phase_q < half_q);
  assign en_scan  = en_q;
  assign pix_idx  = pix_q;
  assign eng_idle = (state_q == ST_IDLE);

  // R6: the pixel clock is gated by the enable
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_clk |-> en_scan) else $error("pix_clk high without en_scan");
  // R5: index stays inside the line
  p_idx_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_idx <= LAST_PIX) else $error("pix_idx out of range");
  // R3: phase stays inside the latched period
  p_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (phase_q < per_q)) else $error("phase overrun");
  // R7: a line edge outside a frame starts nothing
  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && rise && !frame_lvl) |=> (state_q == ST_IDLE && !en_scan))
    else $error("line accepted outside frame");
  // R1: enable only rises inside a frame
  p_en_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_scan) |-> $past(frame_lvl)) else $error("enable rose outside frame");
endmodule

// File: rtl/line_tracker.sv
module line_tracker #(
  parameter int NUM_LINES = 256,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_end,
  input  logic              line_abort,
  input  logic              frame_lvl,
  input  logic              eng_idle,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_done,
  output logic              short_err
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

  logic [LINE_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;
  logic              done_q, done_d;
  logic              err_q, err_d;

  always_comb begin
    cnt_en = line_end | (~frame_lvl & eng_idle);
    cnt_d  = cnt_q;
    if (line_end) cnt_d = (cnt_q == LAST_LINE) ? '0 : cnt_q + LINE_W'(1);
    else          cnt_d = '0;
    done_d = line_end & (cnt_q == LAST_LINE);
    err_d  = err_q | line_abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign line_idx   = cnt_q;
  assign frame_done = done_q;
  assign short_err  = err_q;

  // R9: the error flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    short_err |=> short_err) else $error("short_err cleared");
  // R8: frame-done is a single-cycle pulse
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done) else $error("frame_done longer than one cycle");
  // R8: the line count wraps together with frame-done
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (line_idx == '0)) else $error("line_idx not wrapped");
endmodule

// File: rtl/scan_pixclk_gen.sv
module scan_pixclk_gen #(
  parameter int NUM_PIX   = 256,
  parameter int NUM_LINES = 256,
  parameter int PER_W     = 16,
  parameter int DLY_W     = 16,
  localparam int PIX_W    = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1,
  localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              frame_in,
  input  logic [PER_W-1:0]  cfg_period,
  input  logic [DLY_W-1:0]  cfg_delay,
  output logic              pix_clk,
  output logic              en_scan,
  output logic [PIX_W-1:0]  pix_idx,
  output logic [LINE_W-1:0] line_idx,
  output logic              frame_done,
  output logic              short_err
);
  logic       rst_meta_q, rst_sync_q;
  logic [1:0] lvl;
  logic       line_end, line_abort, eng_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scan_sync #(.NSIG(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .async_in ({frame_in, line_in}),
    .lvl      (lvl)
  );

  pix_engine #(.NUM_PIX(NUM_PIX), .PER_W(PER_W), .DLY_W(DLY_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .line_lvl   (lvl[0]),
    .frame_lvl  (lvl[1]),
    .cfg_period (cfg_period),
    .cfg_delay  (cfg_delay),
    .pix_clk    (pix_clk),
    .en_scan    (en_scan),
    .pix_idx    (pix_idx),
    .line_end   (line_end),
    .line_abort (line_abort),
    .eng_idle   (eng_idle)
  );

  line_tracker #(.NUM_LINES(NUM_LINES)) u_trk (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .line_end   (line_end),
    .line_abort (line_abort),
    .frame_lvl  (lvl[1]),
    .eng_idle   (eng_idle),
    .line_idx   (line_idx),
    .frame_done (frame_done),
    .short_err  (short_err)
  );
endmodule

// File: tb/tb_scan_pixclk_gen.sv
module tb_scan_pixclk_gen;
  localparam int N  = 8;
  localparam int NL = 3;
  localparam int PW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          line_in, frame_in;
  logic [PW-1:0] cfg_period;
  logic [DW-1:0] cfg_delay;
  logic          pix_clk, en_scan, frame_done, short_err;
  logic [2:0]    pix_idx;
  logic [1:0]    line_idx;

  int tests = 0;
  int fails = 0;
  int exp_line = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  scan_pixclk_gen #(.NUM_PIX(N), .NUM_LINES(NL), .PER_W(PW), .DLY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .frame_in(frame_in),
    .cfg_period(cfg_period), .cfg_delay(cfg_delay), .pix_clk(pix_clk),
    .en_scan(en_scan), .pix_idx(pix_idx), .line_idx(line_idx),
    .frame_done(frame_done), .short_err(short_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff_per(input int p);
    return (p < 2) ? 2 : p;
  endfunction

  // kind: 0 full line, 1 short line, 2 line outside frame
  task automatic run_line(input int p, input int d, input int kind);
    int pe, hold, c, en_rise, first_rise, rises, high, sp_err, idx_err;
    int last_rise, gate_err, dones, en_fall, err_before, line_before;
    bit prev_pix;
    pe = eff_per(p);
    hold = (kind == 1) ? 4 + d + 2 * pe : 4 + d + N * pe + 4;
    if (kind == 2) hold = 20;
    err_before = short_err; line_before = line_idx;
    en_rise = -1; first_rise = -1; rises = 0; high = 0; sp_err = 0; idx_err = 0;
    last_rise = -1; gate_err = 0; dones = 0; en_fall = -1; prev_pix = 0;
    @(negedge clk);
    cfg_period = PW'(p); cfg_delay = DW'(d); line_in = 1'b1;
    for (int k = 1; k <= hold + 10; k++) begin
      @(negedge clk);
      c = k;
      if (c == 5) begin // R11: change config mid-line
        cfg_period = PW'(p + 3); cfg_delay = DW'(d + 7);
      end
      if (c == hold) line_in = 1'b0;
      if (en_scan && en_rise < 0) en_rise = c;
      if (!en_scan && en_rise >= 0 && en_fall < 0) en_fall = c;
      if (pix_clk && !en_scan) gate_err++;
      if (pix_clk) high++;
      if (pix_clk && !prev_pix) begin
        if (first_rise < 0) first_rise = c;
        if (last_rise >= 0 && c - last_rise != pe) sp_err++;
        if (int'(pix_idx) != rises) idx_err++;
        last_rise = c;
        rises++;
      end
      if (frame_done) dones++;
      prev_pix = pix_clk;
    end
    if (kind == 2) begin
      chk("R7 en_scan outside frame", (en_rise < 0) ? 0 : 1, 0);
      chk("R7 pix_clk outside frame", rises, 0);
      chk("R7 line_idx outside frame", line_idx, 0);
      chk("R7 short_err outside frame", short_err, err_before);
      exp_line = 0;
      return;
    end
    chk("R6 pix_clk gated by en_scan", gate_err, 0);
    chk("R1 en_scan rise edge", en_rise, 3);
    chk("R2 first pixel edge", first_rise, 4 + d);
    chk("R6 en_scan fall edge", en_fall - hold, 3);
    if (kind == 0) begin
      chk("R3 pixel count", rises, N);
      chk("R3 R4 R11 period spacing errors", sp_err, 0);
      chk("R3 high cycles", high, N * (pe / 2));
      chk("R5 index errors", idx_err, 0);
      exp_line = (exp_line + 1) % NL;
      chk("R8 frame_done pulses", dones, (exp_line == 0) ? 1 : 0);
      chk("R8 line_idx", line_idx, exp_line);
    end else begin
      chk("R9 pixels stopped early", (rises >= 1 && rises < N) ? 1 : 0, 1);
      chk("R9 no pixel after enable fell", (last_rise <= en_fall) ? 1 : 0, 1);
      chk("R9 short_err set", short_err, 1);
      chk("R9 short line not counted", line_idx, line_before);
    end
  endtask

  initial begin
    rst_n = 1'b0; line_in = 1'b0; frame_in = 1'b0;
    cfg_period = PW'(4); cfg_delay = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 outputs in reset",
        int'({pix_clk, en_scan, pix_idx, line_idx, frame_done, short_err}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    frame_in = 1'b1;
    repeat (4) @(negedge clk);
    run_line(2, 0, 0);
    run_line(1, 5, 0);  // R4: clamped to 2
    run_line(0, 3, 0);  // third line ends the frame
    run_line(5, 2, 1);  // short line
    frame_in = 1'b0;
    repeat (6) @(negedge clk);
    run_line(4, 1, 2);  // outside frame
    frame_in = 1'b1;
    repeat (4) @(negedge clk);
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin
      run_line(int'($urandom_range(9, 2)), int'($urandom_range(12, 0)), 0);
    end
    chk("R9 short_err still set", short_err, 1);
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done_flag) begin
      done_flag = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule